// File: doc/BRIEF.md
# Serial Frame Timing and Receive Timeout

This block turns a serial port's configuration words into timing. It decodes an 8-bit format word into a data length, a parity setting, a stop-bit count and the total number of bits on the line per character. It also divides the system clock into a single-cycle bit-rate tick, using an optional fixed prescaler and two programmable divide stages.

The bit-rate tick drives a receive-idle timer. A received-character strobe arms the timer and loads it with four character times, counted in bit ticks. When that count runs out before another character arrives, the block emits a one-cycle timeout pulse and the timer then stays idle. A separate restart strobe lets control logic push out the deadline of an armed timer. Bit sampling, shifting and interrupt bookkeeping are handled in neighbouring blocks.

Top module: `uart_frame_timer`

## Requirements
- R1: Format bits [2:1] select the data length: 2'b11 gives 6 bits, 2'b10 gives 7 bits, and 2'b00 or 2'b01 gives 8 bits. The result appears on `data_bits`.
- R2: Format bits [5:3] select parity: 3'b000 enables even parity, 3'b001 enables odd parity, and every other code turns parity off. `parity_en` is 1 when parity is on, and `parity_odd` is 1 only for code 3'b001.
- R3: Format bits [7:6] select the stop bits: 2'b11 gives one stop bit and every other code gives two.
- R4: `frame_bits` equals 1 + data length + (1 if parity is on) + stop bits, so it always lies between 8 and 12.
- R5: When format bit 0 is 0 and `brg_div` is 2 or more, consecutive `baud_tick` pulses are exactly `brg_div` × (`bdiv_cfg` + 1) clock cycles apart.
- R6: When format bit 0 is 1, the spacing in R5 is multiplied by 8.
- R7: When `brg_div` is 0 or 1, `baud_tick` stays low from the next cycle onward.
- R8: Each `baud_tick` pulse lasts exactly one clock cycle.
- R9: After an `rx_char` strobe, `timeout_pulse` rises in the cycle after the (4 × `frame_bits`)-th `baud_tick` seen in the cycles that follow the strobe, provided no further strobe arrives. A tick in the same cycle as a strobe is not counted.
- R10: A new `rx_char` strobe before expiry reloads the full count, and no pulse appears in the cycle after a strobe.
- R11: `timeout_pulse` lasts one cycle. After it the timer is idle and raises no further pulse until the next `rx_char`.
- R12: A `to_restart` strobe reloads an armed timer with the full count. On an idle timer it has no effect and no pulse follows.
- R13: While `rst_n` is low, and in the first cycle after reset, both `baud_tick` and `timeout_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_cfg | input | 8 | Character format word (bit 0 selects the prescaler) |
| brg_div | input | 16 | First bit-rate divisor; a value of 0 or 1 stops the tick |
| bdiv_cfg | input | 8 | Second divisor minus one |
| rx_char | input | 1 | One-cycle strobe for each accepted received character |
| to_restart | input | 1 | One-cycle strobe that reloads an armed timeout |
| baud_tick | output | 1 | One-cycle bit-rate tick |
| data_bits | output | 4 | Decoded data length (6 to 8) |
| parity_en | output | 1 | Parity is enabled |
| parity_odd | output | 1 | Parity is odd (valid when parity_en is 1) |
| stop_bits | output | 2 | Decoded stop-bit count (1 or 2) |
| frame_bits | output | 4 | Total bits per character on the line |
| timeout_pulse | output | 1 | One-cycle receive-timeout pulse |

## Verification
Some properties can be checked on every cycle: the pulse widths of the tick and the timeout, silence of the tick while the divisor is 0 or 1, the frame length range, the fact that a timeout always follows a tick, and the absence of a timeout right after a character strobe. Other behaviour can only be shown by the bench's scenarios: the exact tick spacing for each divisor and prescaler setting, the number of ticks before expiry for each format, the reload by a second character or a restart strobe, and the restart strobe having no effect on an idle timer.

// File: rtl/uft_pkg.sv
// Shared types for the serial frame timer.
// Assumes that a character never exceeds 12 bits on the line.
package uft_pkg;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop_bits;
        logic [3:0] frame_bits;
    } frame_fmt_t;

    localparam int FRAME_MAX = 12;

endpackage

// File: rtl/uft_frame_decode.sv
// Turns the format word into data length, parity, stop bits and total
// frame length. Purely combinational; the caller is assumed to hold
// mode_cfg stable while a character is in flight.
module uft_frame_decode
    import uft_pkg::*;
(
    input  logic [7:0]  mode_cfg,
    output frame_fmt_t  fmt
);

    // Decode each format field and sum up the frame length
    always_comb begin
        unique case (mode_cfg[2:1])
            2'b11:   fmt.data_bits = 4'd6;
            2'b10:   fmt.data_bits = 4'd7;
            default: fmt.data_bits = 4'd8;
        endcase
        fmt.par_en    = (mode_cfg[5:4] == 2'b00);
        fmt.par_odd   = (mode_cfg[5:3] == 3'b001);
        fmt.stop_bits = (mode_cfg[7:6] == 2'b11) ? 2'd1 : 2'd2;
        fmt.frame_bits = 4'd1 + fmt.data_bits + {3'b000, fmt.par_en}
                       + {2'b00, fmt.stop_bits};
    end

endmodule

// File: rtl/uft_baud_gen.sv
// Bit-rate tick generator: an optional fixed prescaler, then a divide by
// brg_div, then a divide by (bdiv_cfg + 1). A brg_div below 2 stops the
// tick. Counters wrap on ">=" so that shrinking a divisor while running
// never leaves a counter stuck above its limit.
module uft_baud_gen #(
    parameter int BRG_W    = 16,
    parameter int DIV_W    = 8,
    parameter int PRESCALE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_sel,
    input  logic [BRG_W-1:0] brg_div,
    input  logic [DIV_W-1:0] bdiv_cfg,
    output logic             tick
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PRE_W-1:0] pre_cnt;
    logic             ref_en;
    logic [BRG_W-1:0] brg_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             brg_off;

    assign brg_off = (brg_div < BRG_W'(2));

    generate
        if (PRESCALE > 1) begin : g_pre
            // Free-running prescaler counter
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (pre_cnt == PRE_W'(PRESCALE - 1)) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end
            assign ref_en = pre_sel ? (pre_cnt == PRE_W'(PRESCALE - 1)) : 1'b1;
        end else begin : g_nopre
            assign pre_cnt = '0;
            assign ref_en  = 1'b1;
        end
    endgenerate

    // Two-stage divide of the reference enable into the bit tick
    always_ff @(posedge clk) begin
        if (!rst_n || brg_off) begin
            brg_cnt <= '0;
            div_cnt <= '0;
            tick    <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (ref_en) begin
                if (brg_cnt >= brg_div - 1'b1) begin
                    brg_cnt <= '0;
                    if (div_cnt >= bdiv_cfg) begin
                        div_cnt <= '0;
                        tick    <= 1'b1;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end else begin
                    brg_cnt <= brg_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/uft_rx_timeout.sv
// Receive-idle timer. A character strobe arms it with TO_MULT frame times
// counted in bit ticks; a restart strobe reloads it only while armed. On
// the last tick it emits a one-cycle pulse and goes idle. A strobe
// outranks a tick that arrives in the same cycle.
module uft_rx_timeout #(
    parameter int TO_MULT   = 4,
    parameter int FRAME_MAX = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_char,
    input  logic       restart,
    input  logic [3:0] frame_bits,
    output logic       pulse
);

    localparam int CNT_W = $clog2(FRAME_MAX * TO_MULT + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic             armed;

    assign load_val = CNT_W'(frame_bits) * CNT_W'(TO_MULT);

    // Load, count down on ticks, and fire once at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
            pulse <= 1'b0;
        end else if (rx_char || (restart && armed)) begin
            cnt   <= load_val;
            armed <= 1'b1;
            pulse <= 1'b0;
        end else if (armed && tick) begin
            if (cnt <= CNT_W'(1)) begin
                cnt   <= '0;
                armed <= 1'b0;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt - 1'b1;
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_frame_timer.sv
// Top level: format decode, bit-rate tick and receive-idle timer.
// Assumes all configuration inputs come from registers in the same clock
// domain and that rx_char and to_restart are one-cycle strobes.
module uart_frame_timer
    import uft_pkg::*;
#(
    parameter int BRG_W    = 16,
    parameter int DIV_W    = 8,
    parameter int PRESCALE = 8,
    parameter int TO_MULT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       mode_cfg,
    input  logic [BRG_W-1:0] brg_div,
    input  logic [DIV_W-1:0] bdiv_cfg,
    input  logic             rx_char,
    input  logic             to_restart,
    output logic             baud_tick,
    output logic [3:0]       data_bits,
    output logic             parity_en,
    output logic             parity_odd,
    output logic [1:0]       stop_bits,
    output logic [3:0]       frame_bits,
    output logic             timeout_pulse
);

    frame_fmt_t fmt;

    uft_frame_decode u_decode (
        .mode_cfg (mode_cfg),
        .fmt      (fmt)
    );

    uft_baud_gen #(
        .BRG_W    (BRG_W),
        .DIV_W    (DIV_W),
        .PRESCALE (PRESCALE)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_sel  (mode_cfg[0]),
        .brg_div  (brg_div),
        .bdiv_cfg (bdiv_cfg),
        .tick     (baud_tick)
    );

    uft_rx_timeout #(
        .TO_MULT   (TO_MULT),
        .FRAME_MAX (FRAME_MAX)
    ) u_timeout (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .rx_char    (rx_char),
        .restart    (to_restart),
        .frame_bits (fmt.frame_bits),
        .pulse      (timeout_pulse)
    );

    assign data_bits  = fmt.data_bits;
    assign parity_en  = fmt.par_en;
    assign parity_odd = fmt.par_odd;
    assign stop_bits  = fmt.stop_bits;
    assign frame_bits = fmt.frame_bits;

endmodule

// File: rtl/uft_checker.sv
// Cycle-level properties of the frame timer, attached by bind.
module uft_checker #(
    parameter int BRG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BRG_W-1:0] brg_div,
    input logic             rx_char,
    input logic             baud_tick,
    input logic             timeout_pulse,
    input logic [3:0]       frame_bits
);

    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    assert_tick_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brg_div < BRG_W'(2)) |=> !baud_tick);

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    assert_pulse_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pulse) |-> $past(baud_tick));

    assert_char_blocks_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char |=> !timeout_pulse);

    assert_frame_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_bits >= 4'd8) && (frame_bits <= 4'd12));

endmodule

bind uart_frame_timer uft_checker #(.BRG_W(BRG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .brg_div       (brg_div),
    .rx_char       (rx_char),
    .baud_tick     (baud_tick),
    .timeout_pulse (timeout_pulse),
    .frame_bits    (frame_bits)
);

// File: tb/uart_frame_timer_bench.sv
module uart_frame_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mode_cfg = 8'h00;
    logic [15:0] brg_div = 16'd15;
    logic [7:0]  bdiv_cfg = 8'd0;
    logic        rx_char = 1'b0;
    logic        to_restart = 1'b0;
    logic        baud_tick;
    logic [3:0]  data_bits;
    logic        parity_en;
    logic        parity_odd;
    logic [1:0]  stop_bits;
    logic [3:0]  frame_bits;
    logic        timeout_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    uart_frame_timer u_uart_frame_timer (
        .clk (clk), .rst_n (rst_n), .mode_cfg (mode_cfg), .brg_div (brg_div),
        .bdiv_cfg (bdiv_cfg), .rx_char (rx_char), .to_restart (to_restart),
        .baud_tick (baud_tick), .data_bits (data_bits), .parity_en (parity_en),
        .parity_odd (parity_odd), .stop_bits (stop_bits),
        .frame_bits (frame_bits), .timeout_pulse (timeout_pulse)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int exp_data(logic [7:0] m);
        if (m[2:1] == 2'b11) return 6;
        if (m[2:1] == 2'b10) return 7;
        return 8;
    endfunction
    function automatic int exp_par(logic [7:0] m);
        return (m[5:3] == 3'b000 || m[5:3] == 3'b001) ? 1 : 0;
    endfunction
    function automatic int exp_stop(logic [7:0] m);
        return (m[7:6] == 2'b11) ? 1 : 2;
    endfunction
    function automatic int exp_frame(logic [7:0] m);
        return 1 + exp_data(m) + exp_par(m) + exp_stop(m);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!baud_tick);
    endtask

    task automatic measure(int exp, string req);
        int t0;
        repeat (2) wait_tick();
        t0 = cyc;
        wait_tick();
        check((cyc - t0) == exp, req, cyc - t0, exp);
    endtask

    // strobe one of the two controls for one cycle, ending at a negedge
    task automatic strobe(bit use_restart);
        @(negedge clk);
        if (use_restart) to_restart = 1'b1; else rx_char = 1'b1;
        @(negedge clk);
        to_restart = 1'b0;
        rx_char = 1'b0;
    endtask

    // count ticks from the current negedge until the timeout pulse
    task automatic count_to_pulse(int exp, string req);
        int ticks = 0;
        int guard = 0;
        while (!timeout_pulse && guard < 5000) begin
            if (baud_tick) ticks++;
            @(negedge clk);
            guard++;
        end
        check(timeout_pulse && ticks == exp, req, ticks, exp);
    endtask

    task automatic skip_ticks(int k, string req);
        int seen = 0;
        int pulses = 0;
        while (seen < k) begin
            @(negedge clk);
            if (baud_tick) seen++;
            if (timeout_pulse) pulses++;
        end
        check(pulses == 0, req, pulses, 0);
    endtask

    task automatic watch_quiet(int n, string req);
        int pulses = 0;
        repeat (n) begin
            @(negedge clk);
            if (timeout_pulse) pulses++;
        end
        check(pulses == 0, req, pulses, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R13: outputs idle during reset and just after it
        repeat (3) @(negedge clk);
        check(baud_tick == 0 && timeout_pulse == 0, "R13", {baud_tick, timeout_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(baud_tick == 0 && timeout_pulse == 0, "R13", {baud_tick, timeout_pulse}, 0);

        // R1..R4: exhaustive decode of the format word
        for (int m = 0; m < 256; m++) begin
            mode_cfg = 8'(m);
            #1;
            check(int'(data_bits) == exp_data(mode_cfg), "R1", data_bits, exp_data(mode_cfg));
            check(int'(parity_en) == exp_par(mode_cfg) &&
                  parity_odd == (mode_cfg[5:3] == 3'b001), "R2",
                  {parity_en, parity_odd}, exp_par(mode_cfg));
            check(int'(stop_bits) == exp_stop(mode_cfg), "R3", stop_bits, exp_stop(mode_cfg));
            check(int'(frame_bits) == exp_frame(mode_cfg), "R4", frame_bits, exp_frame(mode_cfg));
        end

        // R5, R8: directed minimum divisor and reset-value divisor
        @(negedge clk);
        mode_cfg = 8'h00; brg_div = 16'd2; bdiv_cfg = 8'd0;
        measure(2, "R5 min");
        brg_div = 16'd15; bdiv_cfg = 8'd1;
        measure(30, "R5");
        // R5, R6: random divisors with and without prescaler
        for (int i = 0; i < 12; i++) begin
            int b, d, p;
            b = $urandom_range(6, 2);
            d = $urandom_range(3, 0);
            p = $urandom_range(1, 0);
            @(negedge clk);
            brg_div = 16'(b); bdiv_cfg = 8'(d); mode_cfg = {7'h00, p[0]};
            measure(b * (d + 1) * (p ? 8 : 1), p ? "R6" : "R5");
        end

        // R7: divisor 0 and 1 stop the tick
        for (int v = 0; v < 2; v++) begin
            int cnt = 0;
            @(negedge clk);
            brg_div = 16'(v);
            @(negedge clk);
            repeat (300) begin
                @(negedge clk);
                if (baud_tick) cnt++;
            end
            check(cnt == 0, "R7", cnt, 0);
        end

        // R9: timeout length for the extreme formats and random ones
        @(negedge clk);
        brg_div = 16'd2; bdiv_cfg = 8'd0;
        mode_cfg = 8'h00;
        strobe(0);
        count_to_pulse(48, "R9 longest");
        mode_cfg = 8'hFE;
        strobe(0);
        count_to_pulse(32, "R9 shortest");
        for (int i = 0; i < 6; i++) begin
            mode_cfg = 8'($urandom_range(255, 0)) & 8'hFE;
            strobe(0);
            count_to_pulse(4 * exp_frame(mode_cfg), "R9");
        end

        // R11: no further pulse once expired
        watch_quiet(300, "R11");

        // R10: second character before expiry reloads the count
        mode_cfg = 8'h06;
        strobe(0);
        skip_ticks(20, "R10");
        strobe(0);
        count_to_pulse(4 * exp_frame(8'h06), "R10");

        // R12: restart on an idle timer does nothing
        strobe(1);
        watch_quiet(300, "R12 idle");
        // R12: restart on an armed timer reloads the full count
        mode_cfg = 8'h3C;
        strobe(0);
        skip_ticks(7, "R12");
        strobe(1);
        count_to_pulse(4 * exp_frame(8'h3C), "R12 armed");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule